// File: doc/BRIEF.md
# Gated Load Pulse Generator

This block issues a single-cycle load strobe after a conversion-complete signal rises. The strobe is not issued immediately. It waits until two inputs have been quiet for a fixed settle time. The first is the conversion-complete input itself. The second is a line-valid input. A rising edge of conversion-complete arms the block. The strobe is released only when all of the following hold in the same cycle:

- the arm is still set;
- conversion-complete is high;
- line-valid is low;
- both inputs have held their level for the settle time.

Everything runs on one clock. Input edges are found by comparing each input with a copy of it registered one cycle earlier. No data signal is ever used as a clock. Both inputs are assumed to be synchronous to this clock already.

Reset is synchronous and active high. Each input has its own settle counter. A counter restarts on either edge of its input, counts clock cycles and stops at the settle value `SETTLE_CYCLES`. Reset sets both counters to that value, clears the arm and the strobe, and clears the registered copies of both inputs.

Top module: `loadPulseGen`

## Requirements
- R1: While `rst` is high, and in the cycle after it is released, `loadPulse` is 0. With `adcDone` held low after reset, `loadPulse` stays 0.
- R2: Suppose `adcDone` goes from 0 to 1 while `lineValid` is low and neither input has another edge. Then `loadPulse` is high in the cycle that begins at the sixth rising clock edge after the change, which is `SETTLE_CYCLES`+2 edges.
- R3: `loadPulse` is high for exactly one clock cycle. After it fires, no further pulse occurs until the next 0-to-1 change of `adcDone`, even if `lineValid` toggles.
- R4: Any change of `lineValid`, rising or falling, restarts its settle count. No pulse occurs before the (`SETTLE_CYCLES`+2)th rising edge after the last change of `lineValid`.
- R5: A 1-to-0 change of `adcDone` restarts its settle count. No pulse occurs while `adcDone` is low.
- R6: While `lineValid` is high, no pulse occurs and the arm is kept. The held pulse appears `SETTLE_CYCLES`+2 edges after `lineValid` returns low.
- R7: A new 0-to-1 change of `adcDone` while the block is already armed leaves it armed. It produces a single pulse, timed from the newest change.
- R8: The settle counters hold at `SETTLE_CYCLES` and do not wrap. A hold-off of any length therefore still ends with the pulse `SETTLE_CYCLES`+2 edges after the blocking condition clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all state |
| rst | input | 1 | Synchronous reset, active high |
| adcDone | input | 1 | Conversion-complete level; its rising edge arms the pulse |
| lineValid | input | 1 | Line-active level; high blocks the pulse and its edges restart a settle count |
| loadPulse | output | 1 | Registered single-cycle load strobe |

## Verification
The bench uses the default `SETTLE_CYCLES` of 4, which gives 3-bit settle counters. At this setting every expected pulse lands exactly six edges after the releasing event, so the timing can be checked to the cycle.

Two hold-offs are run while `lineValid` is high, one of 12 cycles and one of 20. A counter that wrapped at 8 would read below 4 at the release point in both cases. The bench would then see a late or missing pulse, so these runs bring the saturation behaviour within reach.

// File: rtl/lpg_pkg.sv
`timescale 1ns/1ps
package lpg_pkg;

  // Strobes handed from the edge/settle datapath to the arming control.
  typedef struct packed {
    logic adcRise;     // adcDone went 0->1 this cycle
    logic anyEdge;     // either input changed this cycle
    logic adcSettled;  // adcDone settle count at its limit
    logic lvSettled;   // lineValid settle count at its limit
    logic adcHigh;     // current adcDone level
    logic lvLow;       // current lineValid level, inverted
  } lpgStrobes_t;

  localparam int ADC_CH = 0;
  localparam int LV_CH  = 1;
  localparam int NUM_CH = 2;

endpackage

// File: rtl/sigTracker.sv
`timescale 1ns/1ps
// One input channel: one-cycle delayed copy, edge strobe and a
// saturating count of cycles since the last edge.
module sigTracker #(
  parameter int SETTLE_CYCLES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic sigIn,
  output logic sigEdge,
  output logic settled
);
  localparam int CW = $clog2(SETTLE_CYCLES + 1);
  localparam logic [CW-1:0] SAT = CW'(SETTLE_CYCLES);

  logic          sigDly;
  logic [CW-1:0] quietCnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sigDly <= 1'b0;
    end else begin
      sigDly <= sigIn;
    end
  end

  assign sigEdge = sigIn ^ sigDly;

  always_ff @(posedge clk) begin
    if (rst) begin
      quietCnt <= SAT;
    end else if (sigEdge) begin
      quietCnt <= '0;
    end else if (quietCnt != SAT) begin
      quietCnt <= quietCnt + 1'b1;
    end
  end

  assign settled = (quietCnt == SAT);

endmodule

// File: rtl/lpgDatapath.sv
`timescale 1ns/1ps
module lpgDatapath
  import lpg_pkg::*;
#(
  parameter int SETTLE_CYCLES = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        adcDone,
  input  logic        lineValid,
  output lpgStrobes_t strobes
);
  logic [NUM_CH-1:0] chIn;
  logic [NUM_CH-1:0] chEdge;
  logic [NUM_CH-1:0] chSettled;

  assign chIn[ADC_CH] = adcDone;
  assign chIn[LV_CH]  = lineValid;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_track
    sigTracker #(
      .SETTLE_CYCLES(SETTLE_CYCLES)
    ) u_track (
      .clk    (clk),
      .rst    (rst),
      .sigIn  (chIn[ch]),
      .sigEdge(chEdge[ch]),
      .settled(chSettled[ch])
    );
  end

  always_comb begin
    strobes.adcRise    = chEdge[ADC_CH] & chIn[ADC_CH];
    strobes.anyEdge    = |chEdge;
    strobes.adcSettled = chSettled[ADC_CH];
    strobes.lvSettled  = chSettled[LV_CH];
    strobes.adcHigh    = chIn[ADC_CH];
    strobes.lvLow      = ~chIn[LV_CH];
  end

endmodule

// File: rtl/lpgControl.sv
`timescale 1ns/1ps
module lpgControl
  import lpg_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  lpgStrobes_t strobes,
  output logic        loadPulse
);
  logic armed;
  logic fire;

  // Release only in a quiet cycle with both counts at their limit.
  always_comb begin
    fire = armed
         & strobes.adcHigh
         & strobes.lvLow
         & strobes.adcSettled
         & strobes.lvSettled
         & ~strobes.anyEdge;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      armed     <= 1'b0;
      loadPulse <= 1'b0;
    end else begin
      armed     <= (armed & ~fire) | strobes.adcRise;
      loadPulse <= fire;
    end
  end

endmodule

// File: rtl/loadPulseGen.sv
`timescale 1ns/1ps
module loadPulseGen
  import lpg_pkg::*;
#(
  parameter int SETTLE_CYCLES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic adcDone,
  input  logic lineValid,
  output logic loadPulse
);
  lpgStrobes_t strobes;

  lpgDatapath #(
    .SETTLE_CYCLES(SETTLE_CYCLES)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .adcDone  (adcDone),
    .lineValid(lineValid),
    .strobes  (strobes)
  );

  lpgControl u_ctl (
    .clk      (clk),
    .rst      (rst),
    .strobes  (strobes),
    .loadPulse(loadPulse)
  );

endmodule

// File: rtl/loadPulseGen_chk.sv
`timescale 1ns/1ps
module loadPulseGen_chk #(
  parameter int SETTLE_CYCLES = 4
) (
  input logic clk,
  input logic rst,
  input logic adcDone,
  input logic lineValid,
  input logic loadPulse
);
  localparam int AW = $clog2(SETTLE_CYCLES + 2);
  localparam logic [AW-1:0] AGE_MAX = AW'(SETTLE_CYCLES + 1);

  // Independent ages (cycles since each input last changed).
  logic          adcPrev, lvPrev;
  logic [AW-1:0] adcAge, lvAge;

  always_ff @(posedge clk) begin
    if (rst) begin
      adcPrev <= 1'b0;
      lvPrev  <= 1'b0;
      adcAge  <= AGE_MAX;
      lvAge   <= AGE_MAX;
    end else begin
      adcPrev <= adcDone;
      lvPrev  <= lineValid;
      if (adcDone != adcPrev) adcAge <= '0;
      else if (adcAge != AGE_MAX) adcAge <= adcAge + 1'b1;
      if (lineValid != lvPrev) lvAge <= '0;
      else if (lvAge != AGE_MAX) lvAge <= lvAge + 1'b1;
    end
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |=> !loadPulse);

  // R3
  single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    loadPulse |=> !loadPulse);

  // R2
  release_levels_chk: assert property (@(posedge clk) disable iff (rst)
    loadPulse |-> ($past(adcDone) && !$past(lineValid)));

  // R4
  lv_settle_chk: assert property (@(posedge clk) disable iff (rst)
    loadPulse |-> (lvAge > AW'(SETTLE_CYCLES)));

  // R5
  adc_settle_chk: assert property (@(posedge clk) disable iff (rst)
    loadPulse |-> (adcAge > AW'(SETTLE_CYCLES)));

endmodule

bind loadPulseGen loadPulseGen_chk #(
  .SETTLE_CYCLES(SETTLE_CYCLES)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .adcDone  (adcDone),
  .lineValid(lineValid),
  .loadPulse(loadPulse)
);

// File: tb/loadPulseGen_test.sv
`timescale 1ns/1ps
module loadPulseGen_test;
  localparam int SETTLE = 4;
  localparam int LAT    = SETTLE + 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic adcDone = 1'b0;
  logic lineValid = 1'b0;
  logic loadPulse;

  int tick = 0;
  int pulseCount = 0;
  int lastPulseTick = -1;
  int testsRun = 0;
  int testsFailed = 0;

  loadPulseGen #(.SETTLE_CYCLES(SETTLE)) uut (
    .clk      (clk),
    .rst      (rst),
    .adcDone  (adcDone),
    .lineValid(lineValid),
    .loadPulse(loadPulse)
  );

  always #4 clk = ~clk;  // 8 ns period, 125 MHz

  always @(posedge clk) tick <= tick + 1;

  always @(negedge clk) begin
    if (loadPulse === 1'b1) begin
      pulseCount    <= pulseCount + 1;
      lastPulseTick <= tick;
    end
  end

  task automatic checkEq(input string req, input string what, input int act, input int exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic waitNeg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic goIdle();
    @(negedge clk);
    adcDone   = 1'b0;
    lineValid = 1'b0;
    waitNeg(14);
  endtask

  task automatic testReset();
    waitNeg(3);
    checkEq("R1", "loadPulse in reset", int'(loadPulse), 0);
    rst = 1'b0;
    @(negedge clk);
    checkEq("R1", "loadPulse after release", int'(loadPulse), 0);
    waitNeg(20);
    checkEq("R1", "pulses while idle", pulseCount, 0);
  endtask

  task automatic testBasic();
    int base, t0;
    base = pulseCount;
    @(negedge clk);
    adcDone = 1'b1;
    t0 = tick;
    waitNeg(10);
    checkEq("R2", "pulse tick offset", lastPulseTick - t0, LAT);
    checkEq("R3", "one pulse", pulseCount - base, 1);
    lineValid = 1'b1;
    waitNeg(2);
    lineValid = 1'b0;
    waitNeg(12);
    checkEq("R3", "no re-fire after lv toggle", pulseCount - base, 1);
    goIdle();
  endtask

  task automatic testLvEdges();
    int base, t0;
    base = pulseCount;
    @(negedge clk);
    adcDone = 1'b1;
    t0 = tick;
    waitNeg(3);
    lineValid = 1'b1;
    waitNeg(1);
    lineValid = 1'b0;
    waitNeg(14);
    checkEq("R4", "pulse offset after lv blip", lastPulseTick - t0, 10);
    checkEq("R4", "one pulse", pulseCount - base, 1);
    goIdle();
  endtask

  task automatic testAdcFallRerise();
    int base, tr;
    base = pulseCount;
    @(negedge clk);
    adcDone = 1'b1;
    waitNeg(2);
    adcDone = 1'b0;
    waitNeg(15);
    checkEq("R5", "no pulse while adcDone low", pulseCount - base, 0);
    adcDone = 1'b1;
    tr = tick;
    waitNeg(14);
    checkEq("R7", "pulse offset from newest rise", lastPulseTick - tr, LAT);
    checkEq("R7", "single pulse", pulseCount - base, 1);
    goIdle();
  endtask

  task automatic testLvHold(input string req, input int holdCycles);
    int base, tl;
    base = pulseCount;
    @(negedge clk);
    adcDone   = 1'b1;
    lineValid = 1'b1;
    waitNeg(holdCycles);
    checkEq(req, "no pulse while lv high", pulseCount - base, 0);
    lineValid = 1'b0;
    tl = tick;
    waitNeg(14);
    checkEq(req, "pulse offset after lv falls", lastPulseTick - tl, LAT);
    checkEq(req, "single pulse", pulseCount - base, 1);
    goIdle();
  endtask

  initial begin
    testReset();
    testBasic();
    testLvEdges();
    testAdcFallRerise();
    testLvHold("R6", 12);
    testLvHold("R8", 20);
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    #(8 * 100000);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule